// File: doc/BRIEF.md
# Key-Set Ghost Filter and Event Generator

This block sits behind a keyboard matrix scanner. Each scan pass delivers one snapshot of up to eight key entries. An entry is a valid bit, a row number and a column number. The block turns each entry into a scan code. It can optionally treat one designated position as a function modifier, which moves every other key of that pass into an alternate code range. It can also optionally throw away a pass that shows the pattern typical of phantom keys in an undiode matrix.

For every pass it accepts, the block compares the new key set with the set it accepted last time. It then emits an ordered event stream: releases first, then presses, then a one-cycle sync strobe. The block keeps the last accepted set internally, so that the next pass can be compared against it. The events are scan codes only; mapping them to key meanings is left to the consumer.

Events leave one per cycle on a valid/ready handshake. While a stream is in flight, the snapshot input is held off.

Top module: `kbd_ghost_evgen`

## Requirements
- R1: The scan code of an entry is its row shifted left by 3, ORed with its column. The column occupies code bits [2:0] and the row occupies bits [6:3]. Bit 7 of the code is 0 unless R4 applies.
- R2: The valid entries of a snapshot form the new key set in ascending entry index order. Press events follow that order. Release events follow the order of the stored set.
- R3: With `fn_mode_en` high, a valid entry whose scan code equals `FN_CODE` (default 7: row 0, column 7) is not part of the key set. It is never emitted and is not counted by the ghost check. With `fn_mode_en` low, that position is an ordinary key.
- R4: When a function entry as in R3 is present, bit 7 is set in the scan code of every key in the set. This is an offset of 128, the number of matrix positions.
- R5: With `ghost_en` high and at least 3 keys in the set, the snapshot is discarded when some pair of keys shares a row and some pair (possibly a different one) shares a column. A discarded snapshot produces no event and no sync, and leaves the stored set unchanged.
- R6: A snapshot is not discarded when `ghost_en` is low, when the set has fewer than 3 keys, or when only rows (or only columns) are shared.
- R7: For an accepted snapshot, each stored key whose code is absent from the new set yields a release event (`evt_press`=0). All releases come before any press.
- R8: After the releases, every key of the new set yields a press event (`evt_press`=1), including keys that were already held. One `evt_sync` pulse of one cycle follows, and the new set then replaces the stored set.
- R9: A snapshot with no valid entries releases every stored key and then pulses `evt_sync`. After it, the stored set is empty.
- R10: An event is held with stable code and kind while `evt_ready` is low. `snap_ready` is low from an accepted snapshot until after its sync pulse.
- R11: After reset, `snap_ready` is high, `evt_valid` and `evt_sync` are low, and the stored set is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snap_valid | input | 1 | Snapshot offered this cycle |
| snap_ready | output | 1 | Block idle and able to take a snapshot |
| snap_ent_vld | input | 8 | Per-entry valid bits |
| snap_ent_row | input | 32 | Entry rows, 4 bits each, entry i at [4i+3:4i] |
| snap_ent_col | input | 24 | Entry columns, 3 bits each, entry i at [3i+2:3i] |
| fn_mode_en | input | 1 | Enable function-key handling |
| ghost_en | input | 1 | Enable ghost rejection |
| evt_valid | output | 1 | Event available |
| evt_ready | input | 1 | Consumer takes the event |
| evt_press | output | 1 | 1 = press, 0 = release |
| evt_code | output | 8 | Scan code of the event |
| evt_sync | output | 1 | One-cycle end-of-stream strobe |

## Verification
Snapshots are offered with the following patterns:
- A single key, then pairs placed at scattered entry indices. These show whether codes are formed correctly and whether compaction keeps index order.
- Held-plus-new sets. These separate re-press of held keys from release of dropped keys.
- A function entry with `fn_mode_en` on and off. This tells the alternate-map offset apart from ordinary treatment of that position, and shows that the function entry is left out of the ghost count.
- Triangles of keys and disjoint row/column pairs with the filter on. These are rejected, and the following snapshot's releases show that the stored set survived.
- The same triangles with the filter off, and row-only sharing. These must pass.
- A full eight-key set, empty snapshots, and consumer backpressure. These cover the count limits and event holding.

// File: rtl/kbd_ev_pkg.sv
package kbd_ev_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REL  = 2'd1,
    ST_PRS  = 2'd2,
    ST_SYNC = 2'd3
  } ev_state_t;
endpackage

// File: rtl/kbd_pick_first.sv
module kbd_pick_first #(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt_oh,
  output logic [IDX_W-1:0] gnt_idx
);
  logic seen;
  always_comb begin
    gnt_oh  = '0;
    gnt_idx = '0;
    seen    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !seen) begin
        gnt_oh[i] = 1'b1;
        gnt_idx   = IDX_W'(i);
        seen      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/kbd_snap_decode.sv
module kbd_snap_decode #(
  parameter int unsigned N       = 8,
  parameter int unsigned ROW_W   = 4,
  parameter int unsigned COL_W   = 3,
  parameter int unsigned FN_CODE = 7,
  localparam int unsigned POS_W  = ROW_W + COL_W,
  localparam int unsigned CODE_W = POS_W + 1,
  localparam int unsigned CNT_W  = $clog2(N + 1)
) (
  input  logic [N-1:0]        ent_vld,
  input  logic [N*ROW_W-1:0]  ent_row,
  input  logic [N*COL_W-1:0]  ent_col,
  input  logic                fn_en,
  input  logic                ghost_en,
  output logic [N*CODE_W-1:0] set_code,
  output logic [CNT_W-1:0]    set_cnt,
  output logic                reject
);
  localparam logic [POS_W-1:0] FN_POS = POS_W'(FN_CODE);

  logic [POS_W-1:0]  raw  [N];
  logic [CODE_W-1:0] code_v [N];
  logic              fn_v, same_row, same_col;
  int                slot;

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign raw[g] = {ent_row[g*ROW_W +: ROW_W], ent_col[g*COL_W +: COL_W]};
    assign set_code[g*CODE_W +: CODE_W] = code_v[g];
  end

  always_comb begin
    slot     = 0;
    fn_v     = 1'b0;
    same_row = 1'b0;
    same_col = 1'b0;
    for (int k = 0; k < N; k++) code_v[k] = '0;
    // compact valid entries in index order, dropping the function entry
    for (int i = 0; i < N; i++) begin
      if (ent_vld[i]) begin
        if (fn_en && (raw[i] == FN_POS)) begin
          fn_v = 1'b1;
        end else begin
          for (int k = 0; k < N; k++)
            if (k == slot) code_v[k] = {1'b0, raw[i]};
          slot = slot + 1;
        end
      end
    end
    // pairwise row / column sharing over the counted keys
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if ((i < slot) && (j < slot) && (j > i)) begin
          if (code_v[i][POS_W-1:COL_W] == code_v[j][POS_W-1:COL_W]) same_row = 1'b1;
          if (code_v[i][COL_W-1:0] == code_v[j][COL_W-1:0]) same_col = 1'b1;
        end
      end
    end
    // alternate map selection
    if (fn_v) begin
      for (int k = 0; k < N; k++)
        if (k < slot) code_v[k][CODE_W-1] = 1'b1;
    end
  end

  assign set_cnt = CNT_W'(slot);
  assign reject  = ghost_en && (slot >= 3) && same_row && same_col;
endmodule

// File: rtl/kbd_ghost_evgen.sv
module kbd_ghost_evgen
  import kbd_ev_pkg::*;
#(
  parameter int unsigned N_ENT   = 8,
  parameter int unsigned ROW_W   = 4,
  parameter int unsigned COL_W   = 3,
  parameter int unsigned FN_CODE = 7,
  localparam int unsigned POS_W  = ROW_W + COL_W,
  localparam int unsigned CODE_W = POS_W + 1,
  localparam int unsigned CNT_W  = $clog2(N_ENT + 1),
  localparam int unsigned IDX_W  = $clog2(N_ENT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   snap_valid,
  output logic                   snap_ready,
  input  logic [N_ENT-1:0]       snap_ent_vld,
  input  logic [N_ENT*ROW_W-1:0] snap_ent_row,
  input  logic [N_ENT*COL_W-1:0] snap_ent_col,
  input  logic                   fn_mode_en,
  input  logic                   ghost_en,
  output logic                   evt_valid,
  input  logic                   evt_ready,
  output logic                   evt_press,
  output logic [CODE_W-1:0]      evt_code,
  output logic                   evt_sync
);
  logic [N_ENT*CODE_W-1:0] dec_flat;
  logic [CODE_W-1:0]       dec_code [N_ENT];
  logic [CNT_W-1:0]        dec_cnt;
  logic                    dec_reject;

  kbd_snap_decode #(.N(N_ENT), .ROW_W(ROW_W), .COL_W(COL_W), .FN_CODE(FN_CODE)) i_dec (
    .ent_vld(snap_ent_vld), .ent_row(snap_ent_row), .ent_col(snap_ent_col),
    .fn_en(fn_mode_en), .ghost_en(ghost_en),
    .set_code(dec_flat), .set_cnt(dec_cnt), .reject(dec_reject)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_unpack
    assign dec_code[g] = dec_flat[g*CODE_W +: CODE_W];
  end

  ev_state_t         state_q, state_d;
  logic [CODE_W-1:0] prev_code_q [N_ENT];
  logic [CODE_W-1:0] new_code_q  [N_ENT];
  logic [CNT_W-1:0]  prev_cnt_q, new_cnt_q;
  logic [N_ENT-1:0]  rel_q, rel_d, prs_q, prs_d;
  logic [N_ENT-1:0]  rel_init, prs_init, rel_oh, prs_oh, rel_left, prs_left;
  logic [IDX_W-1:0]  rel_idx, prs_idx;
  logic              load_new, upd_prev;

  kbd_pick_first #(.N(N_ENT)) i_pick_rel (.req(rel_q), .gnt_oh(rel_oh), .gnt_idx(rel_idx));
  kbd_pick_first #(.N(N_ENT)) i_pick_prs (.req(prs_q), .gnt_oh(prs_oh), .gnt_idx(prs_idx));

  // release candidates: stored keys missing from the incoming set
  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      logic hit;
      hit = 1'b0;
      for (int j = 0; j < N_ENT; j++)
        if ((j < int'(dec_cnt)) && (dec_code[j] == prev_code_q[i])) hit = 1'b1;
      rel_init[i] = (i < int'(prev_cnt_q)) && !hit;
      prs_init[i] = (i < int'(dec_cnt));
    end
  end

  assign rel_left = rel_q & ~rel_oh;
  assign prs_left = prs_q & ~prs_oh;

  always_comb begin
    state_d  = state_q;
    rel_d    = rel_q;
    prs_d    = prs_q;
    load_new = 1'b0;
    upd_prev = 1'b0;
    case (state_q)
      ST_IDLE: if (snap_valid && !dec_reject) begin
        load_new = 1'b1;
        rel_d    = rel_init;
        prs_d    = prs_init;
        if (rel_init != '0)      state_d = ST_REL;
        else if (dec_cnt != '0)  state_d = ST_PRS;
        else                     state_d = ST_SYNC;
      end
      ST_REL: if (evt_ready) begin
        rel_d = rel_left;
        if (rel_left == '0) state_d = (prs_q != '0) ? ST_PRS : ST_SYNC;
      end
      ST_PRS: if (evt_ready) begin
        prs_d = prs_left;
        if (prs_left == '0) state_d = ST_SYNC;
      end
      default: begin
        upd_prev = 1'b1;
        state_d  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rel_q      <= '0;
      prs_q      <= '0;
      prev_cnt_q <= '0;
      new_cnt_q  <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        prev_code_q[i] <= '0;
        new_code_q[i]  <= '0;
      end
    end else begin
      state_q <= state_d;
      rel_q   <= rel_d;
      prs_q   <= prs_d;
      if (load_new) begin
        new_cnt_q <= dec_cnt;
        for (int i = 0; i < N_ENT; i++) new_code_q[i] <= dec_code[i];
      end
      if (upd_prev) begin
        prev_cnt_q <= new_cnt_q;
        for (int i = 0; i < N_ENT; i++) prev_code_q[i] <= new_code_q[i];
      end
    end
  end

  assign snap_ready = (state_q == ST_IDLE);
  assign evt_valid  = (state_q == ST_REL) || (state_q == ST_PRS);
  assign evt_press  = (state_q == ST_PRS);
  assign evt_sync   = (state_q == ST_SYNC);
  assign evt_code   = (state_q == ST_REL) ? prev_code_q[rel_idx] : new_code_q[prs_idx];

  // R10
  hold_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_code) && $stable(evt_press));
  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid && snap_ready && !dec_reject |=> !snap_ready);
  // R7
  rel_before_prs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_press |=> !(evt_valid && !evt_press));
  // R8
  sync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sync |=> !evt_sync && snap_ready);
  // R5
  reject_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid && snap_ready && dec_reject |=> snap_ready && !evt_valid && !evt_sync);
  // R6
  reject_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_reject |-> ghost_en && (dec_cnt >= 3));
  // R9
  empty_no_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid && snap_ready && !dec_reject && (dec_cnt == '0) |=> !(evt_valid && evt_press));
endmodule

// File: tb/test_kbd_ghost_evgen.sv
module test_kbd_ghost_evgen;
  typedef struct {
    int    kind;
    int    code;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        snap_valid, snap_ready;
  logic [7:0]  snap_ent_vld;
  logic [31:0] snap_ent_row;
  logic [23:0] snap_ent_col;
  logic        fn_mode_en, ghost_en;
  logic        evt_valid, evt_ready, evt_press, evt_sync;
  logic [7:0]  evt_code;

  int   n_chk = 0, n_fail = 0, cyc = 0;
  bit   bp_mode = 0;
  exp_t q[$];
  int   prev_set[$];
  logic [7:0]  t_v;
  logic [31:0] t_r;
  logic [23:0] t_c;

  always #5 clk = ~clk;

  kbd_ghost_evgen i_kbd_ghost_evgen (
    .clk(clk), .rst_n(rst_n), .snap_valid(snap_valid), .snap_ready(snap_ready),
    .snap_ent_vld(snap_ent_vld), .snap_ent_row(snap_ent_row), .snap_ent_col(snap_ent_col),
    .fn_mode_en(fn_mode_en), .ghost_en(ghost_en), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_press(evt_press), .evt_code(evt_code), .evt_sync(evt_sync)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (evt_valid && evt_ready) begin
        if (q.size() == 0) chk(0, "R7 unexpected event", evt_code, -1);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.kind == (evt_press ? 1 : 0), {e.req, " kind"}, evt_press ? 1 : 0, e.kind);
          chk(e.code == int'(evt_code), {e.req, " code"}, evt_code, e.code);
          chk(!snap_ready, "R10 busy during event", snap_ready, 0);
        end
      end
      if (evt_sync) begin
        if (q.size() == 0) chk(0, "R8 unexpected sync", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.kind == 2, {e.req, " sync"}, 2, e.kind);
        end
      end
    end
    evt_ready = bp_mode ? ((cyc % 3) != 2) : 1'b1;
  end

  task automatic clr_ent();
    t_v = '0; t_r = '0; t_c = '0;
  endtask

  task automatic put(input int idx, input int row, input int col);
    t_v[idx] = 1'b1;
    t_r[idx*4 +: 4] = 4'(row);
    t_c[idx*3 +: 3] = 3'(col);
  endtask

  // expected behaviour built from the requirements
  task automatic model(input bit fn, input bit gh, input string req, output bit rej);
    int  nw[$];
    bit  fnf, sr, sc, found;
    fnf = 0; sr = 0; sc = 0; rej = 0;
    for (int i = 0; i < 8; i++) begin
      if (t_v[i]) begin
        int code;
        code = int'(t_r[i*4 +: 4]) * 8 + int'(t_c[i*3 +: 3]);
        if (fn && code == 7) fnf = 1;
        else nw.push_back(code);
      end
    end
    if (gh && nw.size() >= 3) begin
      for (int i = 0; i < nw.size(); i++)
        for (int j = i + 1; j < nw.size(); j++) begin
          if (nw[i] / 8 == nw[j] / 8) sr = 1;
          if (nw[i] % 8 == nw[j] % 8) sc = 1;
        end
      rej = sr && sc;
    end
    if (fnf) for (int k = 0; k < nw.size(); k++) nw[k] += 128;
    if (!rej) begin
      foreach (prev_set[p]) begin
        found = 0;
        foreach (nw[n]) if (nw[n] == prev_set[p]) found = 1;
        if (!found) q.push_back('{0, prev_set[p], req});
      end
      foreach (nw[n]) q.push_back('{1, nw[n], req});
      q.push_back('{2, 0, req});
      prev_set = nw;
    end
  endtask

  task automatic fire(input bit fn, input bit gh, input string req);
    bit rej;
    model(fn, gh, req, rej);
    @(negedge clk);
    while (!snap_ready) @(negedge clk);
    snap_ent_vld = t_v; snap_ent_row = t_r; snap_ent_col = t_c;
    fn_mode_en = fn; ghost_en = gh; snap_valid = 1'b1;
    @(negedge clk);
    snap_valid = 1'b0;
    if (rej) begin
      repeat (3) begin
        @(negedge clk);
        chk(snap_ready && !evt_valid && !evt_sync, {req, " discard"}, snap_ready, 1);
      end
    end else begin
      while (q.size() != 0 || !snap_ready) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; snap_valid = 1'b0; snap_ent_vld = '0; snap_ent_row = '0;
    snap_ent_col = '0; fn_mode_en = 1'b0; ghost_en = 1'b0; evt_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(snap_ready, "R11 snap_ready", snap_ready, 1);
    chk(!evt_valid, "R11 evt_valid", evt_valid, 0);
    chk(!evt_sync, "R11 evt_sync", evt_sync, 0);

    // R1 single key row 3 col 2 -> code 26, and R11 empty stored set (no release)
    clr_ent(); put(0, 3, 2); fire(0, 0, "R1");
    // R2 scattered entries, R7 release of dropped key first
    clr_ent(); put(1, 0, 2); put(5, 9, 5); fire(0, 0, "R2");
    // R8 held key is pressed again together with a new one
    bp_mode = 1;
    clr_ent(); put(0, 9, 5); put(3, 15, 7); put(6, 0, 2); fire(0, 0, "R8");
    // R10 backpressure continued with a release-heavy change
    clr_ent(); put(2, 12, 1); fire(0, 1, "R10");
    bp_mode = 0;
    // R3 and R4: function entry present, other key moves to alternate map
    clr_ent(); put(0, 0, 7); put(4, 4, 1); fire(1, 0, "R4");
    // R3 function handling off: position 7 is an ordinary key
    clr_ent(); put(0, 0, 7); put(4, 4, 1); fire(0, 0, "R3");
    // R5 triangle rejected, stored set kept
    clr_ent(); put(0, 2, 1); put(1, 2, 4); put(2, 5, 1); fire(0, 1, "R5");
    // R5 stored set unchanged: releases come from the pre-reject set
    clr_ent(); put(0, 1, 0); put(1, 1, 1); put(2, 1, 2); fire(0, 1, "R6 row-only");
    // R6 triangle accepted with filter off
    clr_ent(); put(0, 2, 1); put(1, 2, 4); put(2, 5, 1); fire(0, 0, "R6 filter off");
    // R5 disjoint pairs rejected
    clr_ent(); put(0, 3, 0); put(1, 3, 6); put(2, 8, 2); put(3, 10, 2); fire(0, 1, "R5 disjoint");
    // R3 function entry not counted: would otherwise form row and column sharing
    clr_ent(); put(0, 0, 7); put(1, 0, 1); put(2, 3, 7); fire(1, 1, "R3 ghost count");
    // R6 full set with distinct rows and columns
    clr_ent();
    for (int i = 0; i < 8; i++) put(i, i * 2, i);
    fire(0, 1, "R6 full set");
    // R9 empty snapshot releases all, then an empty one gives only sync
    clr_ent(); fire(0, 0, "R9 release all");
    clr_ent(); fire(0, 0, "R9 empty again");
    clr_ent(); put(7, 6, 6); fire(0, 0, "R9 after empty");

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R8 leftover expected", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule